// File: doc/BRIEF.md
# Low-Power Mode and Wake Controller

This block sequences the sleep modes of a small microcontroller core. The instruction decoder raises a WAIT or STOP request; the controller then gates the CPU clock, decides whether the oscillator keeps running, and watches the wake sources (pending interrupts, a periodic wake tick, a received debug command and a synchronous system reset) to decide when and how the core resumes. It produces the CPU clock enable, the oscillator enable, a one-cycle pulse that clears the global interrupt mask, an active-debug flag, and a qualified interrupt-take strobe that applies the mask to hardware requests but never to the software interrupt.

Two configuration bits live here: a debug-enable bit that keeps the oscillator alive in STOP so a debug command can still be received, and a clock-keep bit that keeps a minimal clock alive in STOP so the periodic tick can wake the core. When STOP is left with the oscillator halted, a parameterised start-up count elapses before the CPU clock returns.

States and transitions: RUN goes to WAIT on a WAIT request (which wins over a simultaneous STOP request) and to STOP on a STOP request. WAIT returns to RUN on an unmasked interrupt and goes to DEBUG on a debug command. STOP returns to RUN on an unmasked interrupt or on a tick with clock-keep set (at once when the oscillator was kept, after the start-up count otherwise) and goes to DEBUG on a debug command only when debug-enable is set. DEBUG returns to RUN on a debug-exit strobe. Reset from any state goes to RUN, or to DEBUG when the reset-into-debug input is high.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `sys_rst` is high, each clock edge sets `mode` to RUN (0) with `dbg_en`=0 when `boot_dbg`=0, or to DEBUG (3) with `dbg_en`=1 when `boot_dbg`=1; `keep_clk`=0, `cpu_clk_en`=1, `osc_en`=1, `mask_clr`=0. Mode encoding: 0 RUN, 1 WAIT, 2 STOP, 3 DEBUG.
- R2: A `wait_req` in RUN makes the next edge enter WAIT with `cpu_clk_en`=0 and `mask_clr`=1 at that same edge; `mask_clr` lasts one cycle, `osc_en` stays 1, and `wait_req` wins over a simultaneous `stop_req`.
- R3: In WAIT, any `irq_pend` bit with `gmask`=0 returns the block to RUN at the next edge with `cpu_clk_en`=1.
- R4: In WAIT, `dbg_cmd` moves the block to DEBUG at the next edge with `cpu_clk_en`=1 and `dbg_active`=1, taking priority over a simultaneous interrupt.
- R5: A `stop_req` in RUN with both configuration bits clear enters STOP with `cpu_clk_en`=0 and `osc_en`=0; `cpu_clk_en` is 0 in every STOP cycle.
- R6: With `keep_clk`=1, STOP keeps `osc_en`=1 and `wake_tick` returns to RUN at the next edge; with `keep_clk`=0 the tick leaves the block in STOP.
- R7: With `dbg_en`=1, STOP keeps `osc_en`=1 and `dbg_cmd` moves the block to DEBUG at the next edge.
- R8: In STOP with `dbg_en`=0, `dbg_cmd` is ignored: mode stays STOP and `osc_en` stays 0.
- R9: An unmasked interrupt in STOP with the oscillator halted raises `osc_en` at the next edge; mode stays STOP and `cpu_clk_en` rises exactly `RECOV_CYC` edges after `osc_en`.
- R10: `irq_take` is high in RUN when `swi_req`=1 regardless of `gmask`, or when any `irq_pend` bit is set with `gmask`=0; a masked interrupt wakes neither WAIT nor STOP.
- R11: In DEBUG, `dbg_exit` returns the block to RUN at the next edge; `dbg_active` is 1 exactly when `mode` is DEBUG.
- R12: Reset overrides every wake source: `sys_rst` in STOP with an interrupt pending still yields RUN with `dbg_en`=0; `cfg_we` writes `cfg_dbg_en` and `cfg_keep_clk` into `dbg_en` and `keep_clk` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| sys_rst | input | 1 | Synchronous system reset, active high |
| boot_dbg | input | 1 | Reset into DEBUG instead of RUN |
| wait_req | input | 1 | WAIT request pulse from the decoder |
| stop_req | input | 1 | STOP request pulse from the decoder |
| irq_pend | input | N_IRQ | Pending hardware interrupt lines |
| gmask | input | 1 | Current global interrupt mask |
| swi_req | input | 1 | Software interrupt request |
| wake_tick | input | 1 | Periodic wake tick |
| dbg_cmd | input | 1 | Debug command received strobe |
| dbg_exit | input | 1 | Leave DEBUG strobe |
| cfg_we | input | 1 | Configuration write enable |
| cfg_dbg_en | input | 1 | Debug-enable value to write |
| cfg_keep_clk | input | 1 | Clock-keep value to write |
| cpu_clk_en | output | 1 | CPU clock enable |
| osc_en | output | 1 | Oscillator enable |
| mask_clr | output | 1 | One-cycle global mask clear pulse |
| dbg_active | output | 1 | Core is in active debug mode |
| irq_take | output | 1 | Qualified interrupt accepted in RUN |
| dbg_en | output | 1 | Debug-enable configuration bit |
| keep_clk | output | 1 | STOP clock-keep configuration bit |
| mode | output | 2 | Current state (0 RUN, 1 WAIT, 2 STOP, 3 DEBUG) |

## Verification
The checker watches on every cycle that WAIT entry drops the CPU clock together with a single-cycle mask clear, that STOP never runs the CPU clock, that a kept oscillator stays on in STOP, that an unarmed debug command cannot reach DEBUG, that the debug flag tracks the mode, that the software interrupt is always taken in RUN, and that reset lands in RUN. The exact oscillator start-up latency, the priority of a debug command over an interrupt in WAIT, the tick being ignored without clock-keep, masked interrupts failing to wake, and reset into DEBUG are shown only by the bench's scenarios.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
    typedef enum logic [1:0] {
        PM_RUN  = 2'd0,
        PM_WAIT = 2'd1,
        PM_STOP = 2'd2,
        PM_DBG  = 2'd3
    } pm_state_e;
endpackage

// File: rtl/pmc_cfg.sv
module pmc_cfg (
    input  logic clk,
    input  logic sys_rst,
    input  logic boot_dbg,
    input  logic cfg_we,
    input  logic cfg_dbg_en,
    input  logic cfg_keep_clk,
    output logic dbg_en,
    output logic keep_clk
);
    always_ff @(posedge clk) begin
        if (sys_rst) begin
            dbg_en   <= boot_dbg;
            keep_clk <= 1'b0;
        end else if (cfg_we) begin
            dbg_en   <= cfg_dbg_en;
            keep_clk <= cfg_keep_clk;
        end
    end
endmodule

// File: rtl/pmc_irq_gate.sv
module pmc_irq_gate #(
    parameter int N_IRQ = 8
) (
    input  logic [N_IRQ-1:0] irq_pend,
    input  logic             gmask,
    input  logic             swi_req,
    input  logic             in_run,
    output logic             hw_wake,
    output logic             irq_take
);
    // hardware requests are qualified by the mask; software request is not
    always_comb begin
        hw_wake  = (|irq_pend) && !gmask;
        irq_take = in_run && (swi_req || hw_wake);
    end
endmodule

// File: rtl/pmc_osc_timer.sv
module pmc_osc_timer #(
    parameter int RECOV_CYC = 16
) (
    input  logic clk,
    input  logic sys_rst,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(RECOV_CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(RECOV_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (sys_rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start && !busy) begin
            busy <= 1'b1;
            cnt  <= LOAD;
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end

    assign done = busy && (cnt == '0);
endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
    import pwr_mode_pkg::*;
(
    input  logic      clk,
    input  logic      sys_rst,
    input  logic      boot_dbg,
    input  logic      wait_req,
    input  logic      stop_req,
    input  logic      hw_wake,
    input  logic      wake_tick,
    input  logic      dbg_cmd,
    input  logic      dbg_exit,
    input  logic      dbg_en,
    input  logic      keep_clk,
    input  logic      tmr_busy,
    input  logic      tmr_done,
    output logic      tmr_start,
    output pm_state_e state,
    output logic      cpu_clk_en,
    output logic      osc_en,
    output logic      mask_clr,
    output logic      dbg_active
);
    pm_state_e nxt;
    logic      osc_kept;

    assign osc_kept = dbg_en || keep_clk;

    always_comb begin
        nxt       = state;
        tmr_start = 1'b0;
        if (sys_rst) begin
            nxt = boot_dbg ? PM_DBG : PM_RUN;
        end else begin
            unique case (state)
                PM_RUN: begin
                    if (wait_req)      nxt = PM_WAIT;
                    else if (stop_req) nxt = PM_STOP;
                end
                PM_WAIT: begin
                    if (dbg_cmd)      nxt = PM_DBG;
                    else if (hw_wake) nxt = PM_RUN;
                end
                PM_STOP: begin
                    if (tmr_busy) begin
                        if (tmr_done) nxt = PM_RUN;
                    end else if (dbg_cmd && dbg_en) begin
                        nxt = PM_DBG;
                    end else if (hw_wake || (wake_tick && keep_clk)) begin
                        if (osc_kept) nxt = PM_RUN;
                        else          tmr_start = 1'b1;
                    end
                end
                PM_DBG: begin
                    if (dbg_exit) nxt = PM_RUN;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        state <= nxt;
    end

    always_ff @(posedge clk) begin
        cpu_clk_en <= (nxt == PM_RUN) || (nxt == PM_DBG);
        osc_en     <= (nxt != PM_STOP) || osc_kept || tmr_start || tmr_busy;
        mask_clr   <= !sys_rst && (state == PM_RUN) && (nxt == PM_WAIT);
        dbg_active <= (nxt == PM_DBG);
    end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
#(
    parameter int N_IRQ     = 8,
    parameter int RECOV_CYC = 16
) (
    input  logic             clk,
    input  logic             sys_rst,
    input  logic             boot_dbg,
    input  logic             wait_req,
    input  logic             stop_req,
    input  logic [N_IRQ-1:0] irq_pend,
    input  logic             gmask,
    input  logic             swi_req,
    input  logic             wake_tick,
    input  logic             dbg_cmd,
    input  logic             dbg_exit,
    input  logic             cfg_we,
    input  logic             cfg_dbg_en,
    input  logic             cfg_keep_clk,
    output logic             cpu_clk_en,
    output logic             osc_en,
    output logic             mask_clr,
    output logic             dbg_active,
    output logic             irq_take,
    output logic             dbg_en,
    output logic             keep_clk,
    output logic [1:0]       mode
);
    pm_state_e state;
    logic      hw_wake;
    logic      tmr_start;
    logic      tmr_busy;
    logic      tmr_done;

    assign mode = state;

    pmc_cfg u_cfg (
        .clk          (clk),
        .sys_rst      (sys_rst),
        .boot_dbg     (boot_dbg),
        .cfg_we       (cfg_we),
        .cfg_dbg_en   (cfg_dbg_en),
        .cfg_keep_clk (cfg_keep_clk),
        .dbg_en       (dbg_en),
        .keep_clk     (keep_clk)
    );

    pmc_irq_gate #(.N_IRQ(N_IRQ)) u_gate (
        .irq_pend (irq_pend),
        .gmask    (gmask),
        .swi_req  (swi_req),
        .in_run   (state == PM_RUN),
        .hw_wake  (hw_wake),
        .irq_take (irq_take)
    );

    pmc_osc_timer #(.RECOV_CYC(RECOV_CYC)) u_timer (
        .clk     (clk),
        .sys_rst (sys_rst),
        .start   (tmr_start),
        .busy    (tmr_busy),
        .done    (tmr_done)
    );

    pmc_fsm u_fsm (
        .clk        (clk),
        .sys_rst    (sys_rst),
        .boot_dbg   (boot_dbg),
        .wait_req   (wait_req),
        .stop_req   (stop_req),
        .hw_wake    (hw_wake),
        .wake_tick  (wake_tick),
        .dbg_cmd    (dbg_cmd),
        .dbg_exit   (dbg_exit),
        .dbg_en     (dbg_en),
        .keep_clk   (keep_clk),
        .tmr_busy   (tmr_busy),
        .tmr_done   (tmr_done),
        .tmr_start  (tmr_start),
        .state      (state),
        .cpu_clk_en (cpu_clk_en),
        .osc_en     (osc_en),
        .mask_clr   (mask_clr),
        .dbg_active (dbg_active)
    );
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker
    import pwr_mode_pkg::*;
(
    input logic       clk,
    input logic       sys_rst,
    input logic       boot_dbg,
    input logic       wait_req,
    input logic       swi_req,
    input logic       dbg_cmd,
    input logic       cpu_clk_en,
    input logic       osc_en,
    input logic       mask_clr,
    input logic       dbg_active,
    input logic       irq_take,
    input logic       dbg_en,
    input logic       keep_clk,
    input logic [1:0] mode
);
    assert_wait_entry_R2: assert property (@(posedge clk) disable iff (sys_rst)
        (mode == PM_RUN && wait_req) |=> (mode == PM_WAIT && mask_clr && !cpu_clk_en && osc_en));

    assert_mask_single_R2: assert property (@(posedge clk) disable iff (sys_rst)
        mask_clr |=> !mask_clr);

    assert_stop_no_cpu_R5: assert property (@(posedge clk) disable iff (sys_rst)
        (mode == PM_STOP) |-> !cpu_clk_en);

    assert_osc_kept_R7: assert property (@(posedge clk) disable iff (sys_rst)
        (mode == PM_STOP && $past(mode) == PM_STOP && (dbg_en || keep_clk)
         && ($past(dbg_en) || $past(keep_clk))) |-> osc_en);

    assert_dbg_ignored_R8: assert property (@(posedge clk) disable iff (sys_rst)
        (mode == PM_STOP && !dbg_en && dbg_cmd) |=> (mode != PM_DBG));

    assert_dbg_flag_R11: assert property (@(posedge clk) disable iff (sys_rst)
        dbg_active == (mode == PM_DBG));

    assert_swi_taken_R10: assert property (@(posedge clk) disable iff (sys_rst)
        (mode == PM_RUN && swi_req) |-> irq_take);

    assert_reset_run_R12: assert property (@(posedge clk)
        (sys_rst && !boot_dbg) |=> (mode == PM_RUN && !dbg_en && !keep_clk));
endmodule

bind pwr_mode_ctrl pmc_checker u_chk (
    .clk        (clk),
    .sys_rst    (sys_rst),
    .boot_dbg   (boot_dbg),
    .wait_req   (wait_req),
    .swi_req    (swi_req),
    .dbg_cmd    (dbg_cmd),
    .cpu_clk_en (cpu_clk_en),
    .osc_en     (osc_en),
    .mask_clr   (mask_clr),
    .dbg_active (dbg_active),
    .irq_take   (irq_take),
    .dbg_en     (dbg_en),
    .keep_clk   (keep_clk),
    .mode       (mode)
);

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;
    localparam int NI  = 4;
    localparam int RC  = 4;
    localparam logic [1:0] M_RUN = 2'd0, M_WAIT = 2'd1, M_STOP = 2'd2, M_DBG = 2'd3;

    logic clk = 1'b0;
    logic sys_rst = 1'b1, boot_dbg = 1'b0;
    logic wait_req = 1'b0, stop_req = 1'b0, gmask = 1'b1, swi_req = 1'b0;
    logic wake_tick = 1'b0, dbg_cmd = 1'b0, dbg_exit = 1'b0;
    logic cfg_we = 1'b0, cfg_dbg_en = 1'b0, cfg_keep_clk = 1'b0;
    logic [NI-1:0] irq_pend = '0;
    logic cpu_clk_en, osc_en, mask_clr, dbg_active, irq_take, dbg_en, keep_clk;
    logic [1:0] mode;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        string      req;
        logic [1:0] m;
        logic       cpu, osc, mclr, den;
    } exp_t;
    exp_t q[$];

    always #5 clk = ~clk;

    pwr_mode_ctrl #(.N_IRQ(NI), .RECOV_CYC(RC)) u_pwr_mode_ctrl (
        .clk(clk), .sys_rst(sys_rst), .boot_dbg(boot_dbg),
        .wait_req(wait_req), .stop_req(stop_req), .irq_pend(irq_pend),
        .gmask(gmask), .swi_req(swi_req), .wake_tick(wake_tick),
        .dbg_cmd(dbg_cmd), .dbg_exit(dbg_exit), .cfg_we(cfg_we),
        .cfg_dbg_en(cfg_dbg_en), .cfg_keep_clk(cfg_keep_clk),
        .cpu_clk_en(cpu_clk_en), .osc_en(osc_en), .mask_clr(mask_clr),
        .dbg_active(dbg_active), .irq_take(irq_take), .dbg_en(dbg_en),
        .keep_clk(keep_clk), .mode(mode)
    );

    // monitor: compares outputs shortly after each edge against queued items
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (q.size() > 0) begin
                exp_t e;
                logic [6:0] act, exp;
                e   = q.pop_front();
                act = {mode, cpu_clk_en, osc_en, mask_clr, dbg_active, dbg_en};
                exp = {e.m, e.cpu, e.osc, e.mclr, (e.m == M_DBG), e.den};
                checks++;
                if (act !== exp) begin
                    failures++;
                    $display("FAIL %s {mode,cpu,osc,mclr,dbga,den} act=%b exp=%b", e.req, act, exp);
                end
            end
        end
    end

    // driver: inputs are set at a falling edge; this pushes the expectation for the next rising edge
    task automatic go(input string req, input logic [1:0] m, input logic cpu,
                      input logic osc, input logic mclr, input logic den);
        exp_t e;
        @(posedge clk);
        e.req = req; e.m = m; e.cpu = cpu; e.osc = osc; e.mclr = mclr; e.den = den;
        q.push_back(e);
        @(negedge clk);
        wait_req = 0; stop_req = 0; swi_req = 0; wake_tick = 0;
        dbg_cmd = 0; dbg_exit = 0; cfg_we = 0;
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%b exp=%b", req, act, exp);
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            failures++;
            $display("FAIL watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        go("R1 reset to RUN", M_RUN, 1, 1, 0, 0);
        chk("R1 keep_clk after reset", keep_clk, 1'b0);
        sys_rst = 0;
        go("R1 idle RUN", M_RUN, 1, 1, 0, 0);

        // R10 interrupt qualification in RUN
        gmask = 1; irq_pend = 4'b0010; #1;
        chk("R10 masked hw irq not taken", irq_take, 1'b0);
        swi_req = 1; #1;
        chk("R10 swi taken under mask", irq_take, 1'b1);
        swi_req = 0; gmask = 0; #1;
        chk("R10 unmasked hw irq taken", irq_take, 1'b1);
        irq_pend = '0; gmask = 1; #1;
        chk("R10 no request not taken", irq_take, 1'b0);

        // R2 WAIT entry, wait wins over stop
        wait_req = 1; stop_req = 1;
        go("R2 enter WAIT with mask clear", M_WAIT, 0, 1, 1, 0);
        go("R2 mask clear one cycle", M_WAIT, 0, 1, 0, 0);
        irq_pend = 4'b1000; gmask = 1;
        go("R10 masked irq keeps WAIT", M_WAIT, 0, 1, 0, 0);
        gmask = 0;
        go("R3 unmasked irq wakes WAIT", M_RUN, 1, 1, 0, 0);
        irq_pend = '0;

        // R4 debug command beats interrupt in WAIT
        wait_req = 1;
        go("R2 enter WAIT again", M_WAIT, 0, 1, 1, 0);
        dbg_cmd = 1; irq_pend = 4'b0001;
        go("R4 debug cmd in WAIT", M_DBG, 1, 1, 0, 0);
        irq_pend = '0;
        dbg_exit = 1;
        go("R11 debug exit", M_RUN, 1, 1, 0, 0);

        // R5/R8/R6/R9 plain STOP with oscillator halted
        stop_req = 1;
        go("R5 enter STOP osc off", M_STOP, 0, 0, 0, 0);
        dbg_cmd = 1;
        go("R8 debug cmd ignored", M_STOP, 0, 0, 0, 0);
        wake_tick = 1;
        go("R6 tick ignored without keep", M_STOP, 0, 0, 0, 0);
        gmask = 1; irq_pend = 4'b0100;
        go("R10 masked irq keeps STOP", M_STOP, 0, 0, 0, 0);
        gmask = 0;
        go("R9 osc restarts", M_STOP, 0, 1, 0, 0);
        irq_pend = '0;
        for (int k = 1; k < RC; k++) go("R9 recovery count", M_STOP, 0, 1, 0, 0);
        go("R9 cpu clock after RECOV_CYC", M_RUN, 1, 1, 0, 0);

        // R6 clock-keep in STOP
        cfg_we = 1; cfg_keep_clk = 1; cfg_dbg_en = 0;
        go("R12 cfg write", M_RUN, 1, 1, 0, 0);
        chk("R12 keep_clk written", keep_clk, 1'b1);
        stop_req = 1;
        go("R6 STOP keeps osc", M_STOP, 0, 1, 0, 0);
        wake_tick = 1;
        go("R6 tick wakes at once", M_RUN, 1, 1, 0, 0);

        // R7 debug-enable in STOP
        cfg_we = 1; cfg_keep_clk = 0; cfg_dbg_en = 1;
        go("R12 cfg write dbg_en", M_RUN, 1, 1, 0, 1);
        chk("R12 keep_clk cleared", keep_clk, 1'b0);
        stop_req = 1;
        go("R7 STOP osc kept by dbg_en", M_STOP, 0, 1, 0, 1);
        dbg_cmd = 1;
        go("R7 debug cmd in STOP", M_DBG, 1, 1, 0, 1);
        dbg_exit = 1;
        go("R11 debug exit", M_RUN, 1, 1, 0, 1);

        // R12 reset overrides wake
        cfg_we = 1; cfg_dbg_en = 0;
        go("R12 cfg clear", M_RUN, 1, 1, 0, 0);
        stop_req = 1;
        go("R5 STOP again", M_STOP, 0, 0, 0, 0);
        sys_rst = 1; irq_pend = 4'b1111;
        go("R12 reset beats wake", M_RUN, 1, 1, 0, 0);
        irq_pend = '0; boot_dbg = 1;
        go("R1 reset into debug", M_DBG, 1, 1, 0, 1);
        sys_rst = 0; boot_dbg = 0;
        go("R11 debug held", M_DBG, 1, 1, 0, 1);
        dbg_exit = 1;
        go("R11 exit after boot debug", M_RUN, 1, 1, 0, 1);

        @(posedge clk); #3;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule